// File: doc/BRIEF.md
# Masked Multi-Lane Vector Execution Unit

This unit runs one element-wise arithmetic or compare instruction at a time over vectors kept in a register file that is split across parallel lanes. Element `i` of every vector register sits in lane `i mod NLANE`, at row `i div NLANE` of that lane's bank. An accepted instruction walks the rows of the active vector length, one row per cycle, so each lane handles one element per cycle. It stays busy for the rounded-up quotient of vector length and lane count, with a minimum of one cycle.

A single flag vector holds one bit per element. Compare instructions write it. A data instruction issued with its mask bit set writes only the elements whose flag is set and leaves the rest of the destination as it was. This merge behaviour is what a compare-and-swap sequence needs. A scalar-side element port reads and writes single elements while the unit is idle, which is how a load/store path fills and drains the registers.

Top module: `vx_exec_unit`

## Requirements
- R1: After reset, busy and done are low, every flag bit is 0, every stored element reads 0, and the vector length register holds MVL (16).
- R2: While idle, an element-port write stores `el_wdata` in register `el_reg`, element `el_idx`, and `el_rdata` returns that element combinationally. An element-port write made while busy is ignored.
- R3: An instruction is accepted on a clock edge where `iss_valid` is high and busy is low. From the next cycle, busy stays high for max(1, ceil(VL/4)) cycles. `done` is high in exactly the last of those cycles.
- R4: Opcode 0 writes `va+vb` and opcode 1 writes `va-vb` to `vd`, element by element, modulo 2^32, for every element below VL.
- R5: Opcode 2 writes the low 32 bits of `va*vb` to `vd` for every element below VL.
- R6: Opcode 3 sets flag[i] to the signed result of `va[i] < vb[i]`, and opcode 4 sets it to `va[i] == vb[i]`, for every i below VL whatever the mask bit. Compares write no vector register and leave flags at or above VL unchanged.
- R7: Elements of the destination at index VL or above are never changed.
- R8: With `iss_mask` set, a data opcode writes element i only if flag[i] is 1. Otherwise the destination keeps its old value.
- R9: `iss_valid` while busy is ignored. The running instruction keeps its timing and result, and nothing is queued.
- R10: An instruction with VL = 0 is busy for one cycle, raises done, and writes no register and no flag.
- R11: A write of `vl_in` above 16 sets VL to 16. A VL write while busy is ignored.
- R12: Opcodes 5, 6 and 7 take the normal cycle count but write no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vl_we | input | 1 | Write the vector length register |
| vl_in | input | 8 | New vector length, clamped to MVL |
| iss_valid | input | 1 | Instruction offered |
| iss_op | input | 3 | Opcode (0 add, 1 sub, 2 mul, 3 signed less-than, 4 equal) |
| iss_vd | input | 3 | Destination register |
| iss_va | input | 3 | First source register |
| iss_vb | input | 3 | Second source register |
| iss_mask | input | 1 | Merge under flag mask |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final row of the instruction is being processed |
| el_we | input | 1 | Element-port write strobe |
| el_reg | input | 3 | Element-port register number |
| el_idx | input | 4 | Element-port element index |
| el_wdata | input | 32 | Element-port write data |
| el_rdata | output | 32 | Element-port read data, valid while idle |
| flags | output | 16 | Flag vector, bit i for element i |

## Verification
The source vectors mix signs and overflow, and some element pairs are equal. This separates add from subtract, signed from unsigned less-than, and low-half from full multiplication. Vector lengths of 0, 1, 4, 5, 7, 9, 13, 16 and 20 cover a partly filled last row, an exactly full row, the clamp and the empty instruction. Tail elements are read back to tell a tail write from a clean stop. Masked runs use flag patterns left by earlier compares, so a merge that ignores the mask, or one that applies it inverted, shows up in specific elements. One directed run injects an issue, an element write and a VL write while busy, and checks that none of them disturbs the running instruction.

// File: rtl/vx_pkg.sv
package vx_pkg;

    // Default geometry. NLANE and MVL are powers of two, and NLANE < MVL.
    localparam int VX_NLANE  = 4;
    localparam int VX_NREG   = 8;
    localparam int VX_MVL    = 16;
    localparam int VX_EW     = 32;
    localparam int VX_VLIN_W = 8;

    localparam int VX_RW    = $clog2(VX_NREG);
    localparam int VX_VLW   = $clog2(VX_MVL + 1);
    localparam int VX_IDXW  = $clog2(VX_MVL);
    localparam int VX_LANEW = $clog2(VX_NLANE);
    localparam int VX_ROWS  = VX_MVL / VX_NLANE;
    localparam int VX_ROWW  = (VX_ROWS > 1) ? $clog2(VX_ROWS) : 1;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_SLT  = 3'd3,
        OP_SEQ  = 3'd4,
        OP_RSV5 = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } vx_op_e;

    // Instruction context latched at accept time.
    typedef struct packed {
        vx_op_e               op;
        logic [VX_RW-1:0]     vd;
        logic [VX_RW-1:0]     va;
        logic [VX_RW-1:0]     vb;
        logic                 mask;
        logic [VX_VLW-1:0]    vl;
        logic [VX_ROWW-1:0]   last_row;
    } vx_ctl_t;

    // One lane's ALU output.
    typedef struct packed {
        logic [VX_EW-1:0] data;
        logic             flag;
    } vx_res_t;

    function automatic logic op_writes_data(vx_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
    endfunction

    function automatic logic op_sets_flag(vx_op_e op);
        return (op == OP_SLT) || (op == OP_SEQ);
    endfunction

endpackage

// File: rtl/vx_lane_bank.sv
module vx_lane_bank #(
    parameter int NREG = 8,
    parameter int ROWS = 4,
    parameter int EW   = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NREG)-1:0]  ra_reg,
    input  logic [((ROWS>1)?$clog2(ROWS):1)-1:0] ra_row,
    input  logic [$clog2(NREG)-1:0]  rb_reg,
    input  logic [((ROWS>1)?$clog2(ROWS):1)-1:0] rb_row,
    output logic [EW-1:0]            rdata_a,
    output logic [EW-1:0]            rdata_b,
    input  logic                     we,
    input  logic [$clog2(NREG)-1:0]  w_reg,
    input  logic [((ROWS>1)?$clog2(ROWS):1)-1:0] w_row,
    input  logic [EW-1:0]            wdata
);
    localparam int RW    = $clog2(NREG);
    localparam int ROWW  = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int AW    = RW + ROWW;
    localparam int DEPTH = NREG * ROWS;

    logic [EW-1:0] mem [DEPTH];

    logic [AW-1:0] addr_a, addr_b, addr_w;
    assign addr_a = {ra_reg, ra_row};
    assign addr_b = {rb_reg, rb_row};
    assign addr_w = {w_reg, w_row};

    // Two asynchronous read ports, one synchronous write port.
    assign rdata_a = mem[addr_a];
    assign rdata_b = mem[addr_b];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (we) begin
            mem[addr_w] <= wdata;
        end
    end

endmodule

// File: rtl/vx_lane_alu.sv
module vx_lane_alu
    import vx_pkg::*;
(
    input  vx_op_e            op,
    input  logic [VX_EW-1:0]  a,
    input  logic [VX_EW-1:0]  b,
    output vx_res_t           res
);
    always_comb begin
        res = '0;
        case (op)
            OP_ADD:  res.data = a + b;
            OP_SUB:  res.data = a - b;
            OP_MUL:  res.data = a * b;
            OP_SLT:  res.flag = ($signed(a) < $signed(b));
            OP_SEQ:  res.flag = (a == b);
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/vx_sequencer.sv
module vx_sequencer
    import vx_pkg::*;
#(
    parameter int NLANE = VX_NLANE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                iss_valid,
    input  vx_op_e              iss_op,
    input  logic [VX_RW-1:0]    iss_vd,
    input  logic [VX_RW-1:0]    iss_va,
    input  logic [VX_RW-1:0]    iss_vb,
    input  logic                iss_mask,
    input  logic [VX_VLW-1:0]   vl,
    output logic                busy,
    output logic                done,
    output logic [VX_ROWW-1:0]  row,
    output vx_ctl_t             ctl
);
    localparam int VLW1 = VX_VLW + 1;

    logic                busy_q;
    logic [VX_ROWW-1:0]  row_q;
    vx_ctl_t             ctl_q;
    logic [VLW1-1:0]     nrows;
    logic [VX_ROWW-1:0]  last_new;

    // Rows to visit: ceil(vl / NLANE); an empty vector still spends one row.
    assign nrows    = (VLW1'(vl) + VLW1'(NLANE - 1)) / VLW1'(NLANE);
    assign last_new = (nrows == '0) ? '0 : VX_ROWW'(nrows - 1'b1);

    assign busy = busy_q;
    assign row  = row_q;
    assign ctl  = ctl_q;
    assign done = busy_q && (row_q == ctl_q.last_row);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            row_q  <= '0;
            ctl_q  <= '0;
        end else if (!busy_q) begin
            if (iss_valid) begin
                busy_q         <= 1'b1;
                row_q          <= '0;
                ctl_q.op       <= iss_op;
                ctl_q.vd       <= iss_vd;
                ctl_q.va       <= iss_va;
                ctl_q.vb       <= iss_vb;
                ctl_q.mask     <= iss_mask;
                ctl_q.vl       <= vl;
                ctl_q.last_row <= last_new;
            end
        end else if (done) begin
            busy_q <= 1'b0;
        end else begin
            row_q <= row_q + 1'b1;
        end
    end

    // R3: done only inside a run, run ends right after done, otherwise continues.
    p_done_in_run_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    p_done_ends_run_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    p_run_continues_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && row == $past(row) + 1'b1));
    // R9: an offer during a run leaves the latched context alone.
    p_issue_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && iss_valid) |=> $stable(ctl));

endmodule

// File: rtl/vx_exec_unit.sv
module vx_exec_unit
    import vx_pkg::*;
#(
    parameter int NLANE  = VX_NLANE,
    parameter int NREG   = VX_NREG,
    parameter int MVL    = VX_MVL,
    parameter int EW     = VX_EW,
    parameter int VLIN_W = VX_VLIN_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      vl_we,
    input  logic [VLIN_W-1:0]         vl_in,
    input  logic                      iss_valid,
    input  logic [2:0]                iss_op,
    input  logic [$clog2(NREG)-1:0]   iss_vd,
    input  logic [$clog2(NREG)-1:0]   iss_va,
    input  logic [$clog2(NREG)-1:0]   iss_vb,
    input  logic                      iss_mask,
    output logic                      busy,
    output logic                      done,
    input  logic                      el_we,
    input  logic [$clog2(NREG)-1:0]   el_reg,
    input  logic [$clog2(MVL)-1:0]    el_idx,
    input  logic [EW-1:0]             el_wdata,
    output logic [EW-1:0]             el_rdata,
    output logic [MVL-1:0]            flags
);
    localparam int RW    = $clog2(NREG);
    localparam int LANEW = $clog2(NLANE);
    localparam int ROWS  = MVL / NLANE;
    localparam int ROWW  = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int IDXW  = $clog2(MVL);
    localparam int IDXW1 = IDXW + 1;
    localparam int VLW   = $clog2(MVL + 1);

    logic [VLW-1:0]   vl_q;
    logic [MVL-1:0]   flag_q;
    logic             busy_w, done_w;
    logic [ROWW-1:0]  row_w;
    vx_ctl_t          ctl_w;

    logic [NLANE-1:0] flag_we, flag_val;
    logic [IDXW-1:0]  flag_idx [NLANE];
    logic [EW-1:0]    lane_rd  [NLANE];

    logic [LANEW-1:0] el_lane;
    logic [ROWW-1:0]  el_row;

    assign busy    = busy_w;
    assign done    = done_w;
    assign flags   = flag_q;
    assign el_lane = el_idx[LANEW-1:0];
    assign el_row  = el_idx[IDXW-1:LANEW];
    assign el_rdata = lane_rd[el_lane];

    // Vector length register, clamped to MVL, frozen during a run.
    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q <= VLW'(MVL);
        end else if (vl_we && !busy_w) begin
            vl_q <= (vl_in > VLIN_W'(MVL)) ? VLW'(MVL) : VLW'(vl_in);
        end
    end

    vx_sequencer #(.NLANE(NLANE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .iss_valid (iss_valid),
        .iss_op    (vx_op_e'(iss_op)),
        .iss_vd    (iss_vd),
        .iss_va    (iss_va),
        .iss_vb    (iss_vb),
        .iss_mask  (iss_mask),
        .vl        (vl_q),
        .busy      (busy_w),
        .done      (done_w),
        .row       (row_w),
        .ctl       (ctl_w)
    );

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic [IDXW1-1:0] pos;
        logic             active, exec_we, we;
        logic [RW-1:0]    ra_reg, w_reg;
        logic [ROWW-1:0]  ra_row, w_row;
        logic [EW-1:0]    rda, rdb, wdata;
        vx_res_t          res;

        // Element handled by this lane in the current row.
        assign pos     = IDXW1'(row_w) * IDXW1'(NLANE) + IDXW1'(l);
        assign active  = busy_w && (pos < IDXW1'(ctl_w.vl));
        assign exec_we = active && op_writes_data(ctl_w.op)
                         && (!ctl_w.mask || flag_q[pos[IDXW-1:0]]);

        // Port A and the write port are shared with the element port when idle.
        assign ra_reg = busy_w ? ctl_w.va : el_reg;
        assign ra_row = busy_w ? row_w    : el_row;
        assign we     = busy_w ? exec_we  : (el_we && (el_lane == LANEW'(l)));
        assign w_reg  = busy_w ? ctl_w.vd : el_reg;
        assign w_row  = busy_w ? row_w    : el_row;
        assign wdata  = busy_w ? res.data : el_wdata;

        vx_lane_bank #(.NREG(NREG), .ROWS(ROWS), .EW(EW)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .ra_reg  (ra_reg),
            .ra_row  (ra_row),
            .rb_reg  (ctl_w.vb),
            .rb_row  (row_w),
            .rdata_a (rda),
            .rdata_b (rdb),
            .we      (we),
            .w_reg   (w_reg),
            .w_row   (w_row),
            .wdata   (wdata)
        );

        vx_lane_alu u_alu (
            .op  (ctl_w.op),
            .a   (rda),
            .b   (rdb),
            .res (res)
        );

        assign flag_we[l]  = active && op_sets_flag(ctl_w.op);
        assign flag_val[l] = res.flag;
        assign flag_idx[l] = pos[IDXW-1:0];
        assign lane_rd[l]  = rda;

        // R7: no lane writes past the latched vector length during a run.
        p_tail_untouched_r7: assert property (@(posedge clk) disable iff (rst)
            (busy_w && (pos >= IDXW1'(ctl_w.vl))) |-> !we);
        // R8: a masked run never writes an element whose flag is clear.
        p_mask_blocks_r8: assert property (@(posedge clk) disable iff (rst)
            (busy_w && ctl_w.mask && !flag_q[pos[IDXW-1:0]]) |-> !we);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            for (int l = 0; l < NLANE; l++) begin
                if (flag_we[l]) flag_q[flag_idx[l]] <= flag_val[l];
            end
        end
    end

    // R6: flags move only while an instruction runs.
    p_flags_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !busy_w |=> $stable(flag_q));
    // R11: the length register never exceeds MVL.
    p_vl_bounded_r11: assert property (@(posedge clk) disable iff (rst)
        vl_q <= VLW'(MVL));
    // R11: the length register is frozen during a run.
    p_vl_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        busy_w |=> $stable(vl_q));

endmodule

// File: tb/tb_vx_exec_unit.sv
`timescale 1ns/1ps
module tb_vx_exec_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        vl_we;
    logic [7:0]  vl_in;
    logic        iss_valid;
    logic [2:0]  iss_op, iss_vd, iss_va, iss_vb;
    logic        iss_mask;
    logic        busy, done;
    logic        el_we;
    logic [2:0]  el_reg;
    logic [3:0]  el_idx;
    logic [31:0] el_wdata, el_rdata;
    logic [15:0] flags;

    always #2.5 clk = ~clk;

    vx_exec_unit dut (
        .clk(clk), .rst(rst), .vl_we(vl_we), .vl_in(vl_in),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_vd(iss_vd),
        .iss_va(iss_va), .iss_vb(iss_vb), .iss_mask(iss_mask),
        .busy(busy), .done(done), .el_we(el_we), .el_reg(el_reg),
        .el_idx(el_idx), .el_wdata(el_wdata), .el_rdata(el_rdata),
        .flags(flags)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] m  [8][16];
    logic [15:0] mf;

    typedef struct packed {
        logic [2:0] op;
        logic [2:0] vd;
        logic [2:0] va;
        logic [2:0] vb;
        logic       mk;
        logic [7:0] vl;
    } ent_t;

    localparam int NT = 13;
    localparam ent_t TBL [NT] = '{
        '{3'd0, 3'd3, 3'd1, 3'd2, 1'b0, 8'd16},
        '{3'd1, 3'd4, 3'd1, 3'd2, 1'b0, 8'd16},
        '{3'd2, 3'd5, 3'd1, 3'd2, 1'b0, 8'd7},
        '{3'd3, 3'd0, 3'd1, 3'd2, 1'b0, 8'd16},
        '{3'd0, 3'd6, 3'd1, 3'd2, 1'b1, 8'd16},
        '{3'd4, 3'd0, 3'd3, 3'd3, 1'b0, 8'd5},
        '{3'd1, 3'd1, 3'd1, 3'd2, 1'b1, 8'd13},
        '{3'd0, 3'd2, 3'd1, 3'd1, 1'b0, 8'd0},
        '{3'd5, 3'd3, 3'd1, 3'd2, 1'b0, 8'd16},
        '{3'd2, 3'd7, 3'd2, 3'd2, 1'b0, 8'd20},
        '{3'd0, 3'd0, 3'd2, 3'd2, 1'b1, 8'd4},
        '{3'd3, 3'd0, 3'd2, 3'd1, 1'b0, 8'd9},
        '{3'd0, 3'd4, 3'd4, 3'd4, 1'b0, 8'd1}
    };

    function automatic logic [31:0] pat_a(int i);
        return 32'h7FFF_FFF0 + 32'(i) * 32'h1357_9BDF;
    endfunction

    function automatic logic [31:0] pat_b(int i);
        if (i % 4 == 3) return pat_a(i);
        return 32'h0000_0010 - 32'(i) * 32'h0ABC_DEF1;
    endfunction

    function automatic logic [31:0] pat_c(int r, int i);
        return {4'(r), 28'h0} ^ (32'(i) * 32'h0101_0101);
    endfunction

    function automatic string op_tag(logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R4";
            3'd2:       return "R5";
            3'd3, 3'd4: return "R6";
            default:    return "R12";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic el_write(input int r, input int i, input logic [31:0] d);
        @(negedge clk);
        el_we = 1'b1; el_reg = 3'(r); el_idx = 4'(i); el_wdata = d;
        @(negedge clk);
        el_we = 1'b0;
    endtask

    task automatic el_read(input int r, input int i, output logic [31:0] d);
        el_reg = 3'(r); el_idx = 4'(i);
        #1;
        d = el_rdata;
    endtask

    // Issues one instruction and counts its busy cycles and done pulses.
    // With inject set, an issue, an element write and a VL write are offered mid-run.
    task automatic run(input logic [2:0] op, input logic [2:0] vd,
                       input logic [2:0] va, input logic [2:0] vb,
                       input logic mk, input int vlw, input bit inject,
                       output int cyc, output int dn);
        @(negedge clk);
        if (vlw >= 0) begin
            vl_we = 1'b1; vl_in = 8'(vlw);
            @(negedge clk);
            vl_we = 1'b0;
        end
        iss_op = op; iss_vd = vd; iss_va = va; iss_vb = vb; iss_mask = mk;
        iss_valid = 1'b1;
        @(negedge clk);
        iss_valid = 1'b0;
        cyc = 0; dn = 0;
        while (busy === 1'b1 && cyc < 64) begin
            cyc++;
            if (done === 1'b1) dn++;
            if (inject && cyc == 1) begin
                iss_valid = 1'b1; iss_op = 3'd0; iss_vd = 3'd6;
                iss_va = 3'd1; iss_vb = 3'd1; iss_mask = 1'b0;
                el_we = 1'b1; el_reg = 3'd0; el_idx = 4'd0; el_wdata = 32'hDEAD_BEEF;
                vl_we = 1'b1; vl_in = 8'd2;
            end
            if (inject && cyc == 2) begin
                iss_valid = 1'b0; el_we = 1'b0; vl_we = 1'b0;
            end
            @(negedge clk);
        end
        iss_valid = 1'b0; el_we = 1'b0; vl_we = 1'b0;
    endtask

    // Reference behaviour from the requirements.
    task automatic model(input logic [2:0] op, input logic [2:0] vd,
                         input logic [2:0] va, input logic [2:0] vb,
                         input logic mk, input int vle);
        for (int i = 0; i < vle; i++) begin
            logic [31:0] a, b;
            a = m[va][i]; b = m[vb][i];
            case (op)
                3'd0: if (!mk || mf[i]) m[vd][i] = a + b;
                3'd1: if (!mk || mf[i]) m[vd][i] = a - b;
                3'd2: if (!mk || mf[i]) m[vd][i] = a * b;
                3'd3: mf[i] = ($signed(a) < $signed(b));
                3'd4: mf[i] = (a == b);
                default: ;
            endcase
        end
    endtask

    task automatic check_reg(input int r, input string tag, input int vle,
                             input logic mk, input logic [15:0] fl_before);
        for (int i = 0; i < 16; i++) begin
            logic [31:0] d;
            string t;
            el_read(r, i, d);
            if (i >= vle) t = "R7";
            else if (mk && !fl_before[i]) t = "R8";
            else t = tag;
            chk(t, $sformatf("v%0d[%0d]", r, i), d, m[r][i]);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int cyc, dn, vle, expc;
        logic [31:0] d;
        logic [15:0] fb;
        string tg;

        rst = 1'b1; vl_we = 1'b0; vl_in = '0; iss_valid = 1'b0;
        iss_op = '0; iss_vd = '0; iss_va = '0; iss_vb = '0; iss_mask = 1'b0;
        el_we = 1'b0; el_reg = '0; el_idx = '0; el_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "flags", 32'(flags), 32'd0);
        for (int r = 0; r < 8; r++) begin
            el_read(r, 0, d);  chk("R1", $sformatf("v%0d[0]", r), d, 32'd0);
            el_read(r, 15, d); chk("R1", $sformatf("v%0d[15]", r), d, 32'd0);
        end
        // R1: VL resets to 16, so an instruction with no VL write takes 4 cycles
        run(3'd0, 3'd7, 3'd1, 3'd2, 1'b0, -1, 1'b0, cyc, dn);
        chk("R1", "reset VL cycles", 32'(cyc), 32'd4);

        // R2: fill all registers through the element port and read back
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < 16; i++) begin
                m[r][i] = (r == 1) ? pat_a(i) : (r == 2) ? pat_b(i) : pat_c(r, i);
                el_write(r, i, m[r][i]);
            end
        end
        mf = '0;
        @(negedge clk);
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < 16; i++) begin
                el_read(r, i, d);
                chk("R2", $sformatf("load v%0d[%0d]", r, i), d, m[r][i]);
            end
        end

        // Table walk
        for (int t = 0; t < NT; t++) begin
            vle  = (TBL[t].vl > 8'd16) ? 16 : int'(TBL[t].vl);
            expc = (vle == 0) ? 1 : (vle + 3) / 4;
            fb   = mf;
            run(TBL[t].op, TBL[t].vd, TBL[t].va, TBL[t].vb, TBL[t].mk,
                int'(TBL[t].vl), 1'b0, cyc, dn);
            tg = (vle == 0) ? "R10" : (TBL[t].vl > 8'd16) ? "R11" : "R3";
            chk(tg, $sformatf("entry %0d cycles", t), 32'(cyc), 32'(expc));
            chk(tg, $sformatf("entry %0d done pulses", t), 32'(dn), 32'd1);
            model(TBL[t].op, TBL[t].vd, TBL[t].va, TBL[t].vb, TBL[t].mk, vle);
            tg = (vle == 0) ? "R10" : op_tag(TBL[t].op);
            check_reg(int'(TBL[t].vd), tg, vle, TBL[t].mk && (TBL[t].op < 3'd3), fb);
            chk((TBL[t].op == 3'd3 || TBL[t].op == 3'd4) ? "R6" : tg,
                $sformatf("entry %0d flags", t), 32'(flags), 32'(mf));
        end

        // R9/R2/R11: offers during a run are ignored
        run(3'd1, 3'd7, 3'd1, 3'd2, 1'b0, 16, 1'b1, cyc, dn);
        chk("R9", "cycles with issue offered mid-run", 32'(cyc), 32'd4);
        chk("R9", "done pulses", 32'(dn), 32'd1);
        model(3'd1, 3'd7, 3'd1, 3'd2, 1'b0, 16);
        check_reg(7, "R9", 16, 1'b0, mf);
        check_reg(6, "R9", 16, 1'b0, mf);
        el_read(0, 0, d);
        chk("R2", "element write while busy ignored", d, m[0][0]);
        chk("R9", "still idle after run", 32'(busy), 32'd0);
        run(3'd0, 3'd5, 3'd1, 3'd1, 1'b0, -1, 1'b0, cyc, dn);
        chk("R11", "VL write while busy ignored", 32'(cyc), 32'd4);
        model(3'd0, 3'd5, 3'd1, 3'd1, 1'b0, 16);
        check_reg(5, "R4", 16, 1'b0, mf);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule